// File: doc/BRIEF.md
# Octet-Fed HDLC Message Receiver

This block recovers HDLC/LAPD data-link messages that travel as one overhead octet per line frame. On each frame strobe the host-selected overhead field is latched. Which of the two candidate fields is used is set by a static configuration input. The latched octet is shifted out one bit at a time, most significant bit first, into a bit-level deframer. The deframer hunts for the 0x7E flag, deletes stuffed zeros, detects aborts and assembles octets. Octets are taken least significant bit first from the recovered bit stream, which is the usual HDLC order.

Every completed octet feeds a CRC-16 accumulator. Each octet also passes through a two-octet delay, so the trailing frame check octets never reach storage. Only information octets are written, from address 0, into a message buffer of BUF_DEPTH (88) octets. When the closing flag arrives the frame is judged. The result lands in sticky status bits: end of message, flag seen, abort, FCS error, framing error and overflow. The block also reports the stored length and the first information octet, which serves as the message type. The host reads the status outputs, clears them with a one-cycle read strobe, and fetches the stored octets through a read address port.

Top module: `lapd_octet_rx`

## Requirements
- R1: On a cycle with `oh_strobe` high, the octet on `nr_octet` is taken when `src_sel_nr`=1, or the octet on `gc_octet` when it is 0. The other field is ignored. Bit 7 of the taken octet enters the bit stream first.
- R2: A 0 followed by six 1s and a 0 (0x7E) is a flag. Every flag sets `stat_flag`. A flag closes the open frame and opens the next one. A closing flag with no complete octet since the previous flag is idle fill and reports nothing else.
- R3: Inside a frame, a 0 that directly follows five consecutive 1s is removed before octets are assembled. Octets are assembled least significant bit first.
- R4: Information octets (all octets but the last two) are stored at buffer addresses 0, 1, 2, and so on. On a valid closing flag `msg_len` takes the number stored. `buf_rdata` shows the octet at `buf_raddr` one clock after the address is applied.
- R5: The CRC-16 (reflected polynomial 0x8408, preset 0xFFFF) runs over all octets of a frame, including the two frame check octets. On a valid close `stat_eom` is set, and `stat_fcs_err` is set unless the register holds 0xF0B8.
- R6: A seventh consecutive 1 inside a frame aborts it. `stat_abort` is set, no end of message is reported, and the block hunts for the next flag.
- R7: A frame that closes with fewer than 4 octets, or with a bit count that is not a multiple of 8, sets `stat_frm_err`. It does not set `stat_eom` and does not change `msg_len` or `msg_type`.
- R8: Information octets beyond BUF_DEPTH are not stored, `msg_len` saturates at BUF_DEPTH, and `stat_ovf` is set with the end of message.
- R9: `msg_type` takes the first information octet on each valid close. A high `stat_rd` clears all status bits on the next clock edge. A new event in that same cycle stays set.
- R10: After reset all status bits, `msg_len`, `msg_type` and `buf_rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| oh_strobe | input | 1 | One-cycle strobe: the overhead octets of a new line frame are valid |
| gc_octet | input | 8 | First candidate overhead octet |
| nr_octet | input | 8 | Second candidate overhead octet |
| src_sel_nr | input | 1 | 1 selects `nr_octet`, 0 selects `gc_octet` |
| stat_rd | input | 1 | Host status read; clears all status bits |
| stat_eom | output | 1 | Valid frame ended |
| stat_flag | output | 1 | A flag was seen |
| stat_abort | output | 1 | A frame was aborted |
| stat_fcs_err | output | 1 | The last valid frame failed the CRC check |
| stat_frm_err | output | 1 | A frame was too short or not octet-aligned |
| stat_ovf | output | 1 | The last valid frame exceeded the buffer |
| msg_len | output | 7 | Information octets stored for the last valid frame |
| msg_type | output | 8 | First information octet of the last valid frame |
| buf_raddr | input | 7 | Buffer read address |
| buf_rdata | output | 8 | Buffer read data, one cycle after the address |

## Verification
The assertions assume that frame strobes arrive no faster than one per octet time. A new octet must never be loaded while the shifter still has more than one bit left to send. The bench meets this by spacing strobes ten clocks apart. The bench builds its bit streams from flags and correctly stuffed octets, and fills the last partial octet with zeros after a closing flag. This keeps the stream free of accidental seven-ones runs, except in the abort scenario. Status is sampled only after the last octet has drained and the host read strobe is idle.

// File: rtl/lapd_rx_pkg.sv
package lapd_rx_pkg;
   localparam logic [15:0] CRC_PRESET = 16'hFFFF;
   localparam logic [15:0] CRC_POLY_R = 16'h8408;
   localparam logic [15:0] CRC_RESIDUE = 16'hF0B8;

   typedef struct packed {
      logic eom;
      logic flag;
      logic abort;
      logic fcs_err;
      logic frm_err;
      logic ovf;
   } rx_status_t;

   // one octet, least significant bit first, reflected CRC-16
   function automatic logic [15:0] crc16_octet(input logic [15:0] c_in, input logic [7:0] d);
      logic [15:0] c;
      c = c_in;
      for (int i = 0; i < 8; i++) begin
         if (c[0] ^ d[i]) c = (c >> 1) ^ CRC_POLY_R;
         else             c = c >> 1;
      end
      return c;
   endfunction
endpackage

// File: rtl/lapd_octet_shifter.sv
module lapd_octet_shifter #(
   parameter int OCT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [OCT_W-1:0] oct_in,
   output logic             bit_vld,
   output logic             bit_out,
   output logic             busy
);
   localparam int CNT_W = $clog2(OCT_W + 1);

   logic [OCT_W-1:0] sh_q;
   logic [CNT_W-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         left_q <= '0;
      end else if (load) begin
         sh_q   <= oct_in;
         left_q <= CNT_W'(OCT_W);
      end else if (left_q != '0) begin
         sh_q   <= sh_q << 1;
         left_q <= left_q - 1'b1;
      end
   end

   assign bit_vld = (left_q != '0);
   assign bit_out = sh_q[OCT_W-1];
   assign busy    = (left_q > CNT_W'(1));
endmodule

// File: rtl/lapd_bit_deframer.sv
module lapd_bit_deframer #(
   parameter int OCT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_vld,
   input  logic             bit_in,
   output logic             flag_evt,
   output logic             flag_aligned,
   output logic             flag_closes,
   output logic             abort_evt,
   output logic             oct_vld,
   output logic [OCT_W-1:0] oct_data
);
   localparam int ONES_W   = 3;
   localparam int STUFF_AT = 5;
   localparam int FLAG_AT  = 6;
   localparam int POS_W    = $clog2(OCT_W);

   logic [ONES_W-1:0] ones_q;
   logic [OCT_W-1:0]  sh_q;
   logic [POS_W-1:0]  pos_q;
   logic              in_frame_q;
   logic              push;
   logic [OCT_W-1:0]  sh_next;

   always_comb begin
      push = bit_vld && in_frame_q &&
             ((bit_in && ones_q != ONES_W'(FLAG_AT)) || (!bit_in && ones_q < ONES_W'(STUFF_AT)));
      sh_next = {bit_in, sh_q[OCT_W-1:1]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ones_q       <= '0;
         sh_q         <= '0;
         pos_q        <= '0;
         in_frame_q   <= 1'b0;
         flag_evt     <= 1'b0;
         flag_aligned <= 1'b0;
         flag_closes  <= 1'b0;
         abort_evt    <= 1'b0;
         oct_vld      <= 1'b0;
         oct_data     <= '0;
      end else begin
         flag_evt  <= 1'b0;
         abort_evt <= 1'b0;
         oct_vld   <= 1'b0;
         if (bit_vld) begin
            if (bit_in) begin
               if (ones_q != '1) ones_q <= ones_q + 1'b1;
               if (ones_q == ONES_W'(FLAG_AT)) begin
                  abort_evt  <= in_frame_q;
                  in_frame_q <= 1'b0;
               end
            end else begin
               ones_q <= '0;
               if (ones_q == ONES_W'(FLAG_AT)) begin
                  flag_evt     <= 1'b1;
                  flag_aligned <= (pos_q == POS_W'(OCT_W - 1));
                  flag_closes  <= in_frame_q;
                  in_frame_q   <= 1'b1;
                  pos_q        <= '0;
               end
            end
         end
         if (push) begin
            sh_q  <= sh_next;
            pos_q <= pos_q + 1'b1;
            if (pos_q == POS_W'(OCT_W - 1)) begin
               oct_vld  <= 1'b1;
               oct_data <= sh_next;
            end
         end
      end
   end
endmodule

// File: rtl/lapd_octet_rx.sv
module lapd_octet_rx #(
   parameter int BUF_DEPTH = 88,
   parameter int OCT_W     = 8,
   parameter int MIN_OCTS  = 4,
   parameter bit RD_REG    = 1'b1,
   parameter int AW        = $clog2(BUF_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             oh_strobe,
   input  logic [OCT_W-1:0] gc_octet,
   input  logic [OCT_W-1:0] nr_octet,
   input  logic             src_sel_nr,
   input  logic             stat_rd,
   output logic             stat_eom,
   output logic             stat_flag,
   output logic             stat_abort,
   output logic             stat_fcs_err,
   output logic             stat_frm_err,
   output logic             stat_ovf,
   output logic [AW-1:0]    msg_len,
   output logic [OCT_W-1:0] msg_type,
   input  logic [AW-1:0]    buf_raddr,
   output logic [OCT_W-1:0] buf_rdata
);
   import lapd_rx_pkg::*;

   localparam int CNT_W = $clog2(BUF_DEPTH + 3) + 1;

   generate
      if (OCT_W != 8) begin : g_bad_oct
         $error("OCT_W must be 8 for the CRC-16 octet step");
      end
      if (BUF_DEPTH < 1) begin : g_bad_depth
         $error("BUF_DEPTH must be at least 1");
      end
      if (MIN_OCTS < 3) begin : g_bad_min
         $error("MIN_OCTS must cover two check octets plus one");
      end
   endgenerate

   logic             bit_vld, bit_val, shift_busy;
   logic             flag_evt, flag_aligned, flag_closes, abort_evt, oct_vld;
   logic [OCT_W-1:0] oct_data;

   lapd_octet_shifter #(.OCT_W(OCT_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(oh_strobe),
      .oct_in(src_sel_nr ? nr_octet : gc_octet),
      .bit_vld(bit_vld), .bit_out(bit_val), .busy(shift_busy));

   lapd_bit_deframer #(.OCT_W(OCT_W)) u_defr (
      .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_val),
      .flag_evt(flag_evt), .flag_aligned(flag_aligned), .flag_closes(flag_closes),
      .abort_evt(abort_evt), .oct_vld(oct_vld), .oct_data(oct_data));

   logic [15:0]      crc_q;
   logic [OCT_W-1:0] hold1_q, hold2_q, type_q;
   logic [CNT_W-1:0] cnt_q;
   logic [AW-1:0]    wptr;
   logic             ovf_q;
   logic [OCT_W-1:0] mem [BUF_DEPTH];
   logic             wr_info, room;

   assign wr_info = oct_vld && (cnt_q >= CNT_W'(2));
   assign room    = (wptr < AW'(BUF_DEPTH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc_q   <= CRC_PRESET;
         hold1_q <= '0;
         hold2_q <= '0;
         type_q  <= '0;
         cnt_q   <= '0;
         wptr    <= '0;
         ovf_q   <= 1'b0;
      end else if (flag_evt || abort_evt) begin
         crc_q <= CRC_PRESET;
         cnt_q <= '0;
         wptr  <= '0;
         ovf_q <= 1'b0;
      end else if (oct_vld) begin
         crc_q   <= crc16_octet(crc_q, oct_data);
         hold1_q <= oct_data;
         hold2_q <= hold1_q;
         if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
         if (cnt_q == CNT_W'(2)) type_q <= hold2_q;
         if (wr_info) begin
            if (room) wptr <= wptr + 1'b1;
            else      ovf_q <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (wr_info && room) mem[wptr] <= hold2_q;
   end

   logic       close, close_bad, close_ok;
   rx_status_t st_q, st_set;

   always_comb begin
      close     = flag_evt && flag_closes && (cnt_q != '0);
      close_bad = close && (!flag_aligned || cnt_q < CNT_W'(MIN_OCTS));
      close_ok  = close && !close_bad;
      st_set.eom     = close_ok;
      st_set.flag    = flag_evt;
      st_set.abort   = abort_evt;
      st_set.fcs_err = close_ok && (crc_q != CRC_RESIDUE);
      st_set.frm_err = close_bad;
      st_set.ovf     = close_ok && ovf_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= '0;
         msg_len  <= '0;
         msg_type <= '0;
      end else begin
         st_q <= (stat_rd ? rx_status_t'('0) : st_q) | st_set;
         if (close_ok) begin
            msg_len  <= wptr;
            msg_type <= type_q;
         end
      end
   end

   assign stat_eom     = st_q.eom;
   assign stat_flag    = st_q.flag;
   assign stat_abort   = st_q.abort;
   assign stat_fcs_err = st_q.fcs_err;
   assign stat_frm_err = st_q.frm_err;
   assign stat_ovf     = st_q.ovf;

   logic [OCT_W-1:0] rd_word;
   assign rd_word = (buf_raddr < AW'(BUF_DEPTH)) ? mem[buf_raddr] : '0;

   generate
      if (RD_REG) begin : g_rd_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) buf_rdata <= '0;
            else        buf_rdata <= rd_word;
         end
      end else begin : g_rd_comb
         assign buf_rdata = rd_word;
      end
   endgenerate
endmodule

// File: rtl/lapd_octet_rx_chk.sv
module lapd_octet_rx_chk #(
   parameter int BUF_DEPTH = 88,
   parameter int AW        = 7
) (
   input logic          clk,
   input logic          rst_n,
   input logic          oh_strobe,
   input logic          shift_busy,
   input logic          stat_rd,
   input logic          flag_evt,
   input logic          abort_evt,
   input logic          oct_vld,
   input logic          stat_eom,
   input logic          stat_abort,
   input logic          stat_frm_err,
   input logic [AW-1:0] msg_len,
   input logic [AW-1:0] wptr
);
   // input assumption for R1: one octet per octet time
   p_strobe_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
      oh_strobe |-> !shift_busy);

   p_evt_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({flag_evt, abort_evt, oct_vld}));

   p_len_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_evt |=> $stable(msg_len));

   p_abort_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
      abort_evt |=> stat_abort);

   p_eom_frm_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !($rose(stat_eom) && $rose(stat_frm_err)));

   p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_len <= AW'(BUF_DEPTH)) && (wptr <= AW'(BUF_DEPTH)));

   p_clear_on_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !flag_evt && !abort_evt) |=> (!stat_eom && !stat_frm_err && !stat_abort));
endmodule

bind lapd_octet_rx lapd_octet_rx_chk #(.BUF_DEPTH(BUF_DEPTH), .AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .oh_strobe(oh_strobe), .shift_busy(shift_busy),
   .stat_rd(stat_rd), .flag_evt(flag_evt), .abort_evt(abort_evt), .oct_vld(oct_vld),
   .stat_eom(stat_eom), .stat_abort(stat_abort), .stat_frm_err(stat_frm_err),
   .msg_len(msg_len), .wptr(wptr));

// File: tb/lapd_octet_rx_bench.sv
module lapd_octet_rx_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       oh_strobe = 1'b0;
   logic [7:0] gc_octet = 8'h00;
   logic [7:0] nr_octet = 8'h00;
   logic       src_sel_nr = 1'b0;
   logic       stat_rd = 1'b0;
   logic       stat_eom, stat_flag, stat_abort, stat_fcs_err, stat_frm_err, stat_ovf;
   logic [6:0] msg_len;
   logic [7:0] msg_type;
   logic [6:0] buf_raddr = '0;
   logic [7:0] buf_rdata;

   lapd_octet_rx u_lapd_octet_rx (
      .clk(clk), .rst_n(rst_n), .oh_strobe(oh_strobe), .gc_octet(gc_octet),
      .nr_octet(nr_octet), .src_sel_nr(src_sel_nr), .stat_rd(stat_rd),
      .stat_eom(stat_eom), .stat_flag(stat_flag), .stat_abort(stat_abort),
      .stat_fcs_err(stat_fcs_err), .stat_frm_err(stat_frm_err), .stat_ovf(stat_ovf),
      .msg_len(msg_len), .msg_type(msg_type), .buf_raddr(buf_raddr), .buf_rdata(buf_rdata));

   always #10 clk = ~clk;

   int   n_chk = 0;
   int   n_bad = 0;
   logic bits_q [0:2047];
   int   nbits = 0;
   int   ones_run = 0;
   logic [7:0] info [0:127];

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] ref_crc(input logic [15:0] c_in, input logic [7:0] d);
      logic [15:0] c = c_in;
      for (int i = 0; i < 8; i++) begin
         if (c[0] ^ d[i]) c = (c >> 1) ^ 16'h8408;
         else             c = c >> 1;
      end
      return c;
   endfunction

   task automatic put_bit(input logic b);
      bits_q[nbits] = b;
      nbits++;
   endtask

   task automatic put_flag();
      for (int i = 0; i < 8; i++) put_bit((i != 0) && (i != 7));
      ones_run = 0;
   endtask

   task automatic put_octet(input logic [7:0] v);
      for (int i = 0; i < 8; i++) begin
         put_bit(v[i]);
         if (v[i]) begin
            ones_run++;
            if (ones_run == 5) begin
               put_bit(1'b0);
               ones_run = 0;
            end
         end else ones_run = 0;
      end
   endtask

   // opening flag, n info octets, FCS (optionally damaged), closing flag
   task automatic build_frame(input int n, input logic corrupt);
      logic [15:0] c = 16'hFFFF;
      logic [15:0] fcs;
      put_flag();
      for (int i = 0; i < n; i++) begin
         put_octet(info[i]);
         c = ref_crc(c, info[i]);
      end
      fcs = ~c;
      if (corrupt) fcs = fcs ^ 16'h0100;
      put_octet(fcs[7:0]);
      put_octet(fcs[15:8]);
      put_flag();
   endtask

   task automatic send_stream(input logic use_nr);
      logic [7:0] oct;
      while (nbits % 8 != 0) put_bit(1'b0);
      src_sel_nr = use_nr;
      for (int k = 0; k < nbits / 8; k++) begin
         for (int j = 0; j < 8; j++) oct[7-j] = bits_q[k*8+j];
         @(negedge clk);
         gc_octet  = use_nr ? ~oct : oct;
         nr_octet  = use_nr ? oct : ~oct;
         oh_strobe = 1'b1;
         @(negedge clk);
         oh_strobe = 1'b0;
         repeat (8) @(negedge clk);
      end
      repeat (20) @(negedge clk);
      nbits = 0;
      ones_run = 0;
   endtask

   task automatic host_clear();
      @(negedge clk);
      stat_rd = 1'b1;
      @(negedge clk);
      stat_rd = 1'b0;
   endtask

   task automatic read_buf(input int a, output logic [7:0] d);
      @(negedge clk);
      buf_raddr = 7'(a);
      @(negedge clk);
      d = buf_rdata;
   endtask

   task automatic t_reset();
      chk("R10 status", int'({stat_eom, stat_flag, stat_abort, stat_fcs_err, stat_frm_err, stat_ovf}), 0);
      chk("R10 len", int'(msg_len), 0);
      chk("R10 type", int'(msg_type), 0);
      chk("R10 rdata", int'(buf_rdata), 0);
   endtask

   task automatic t_good_gc();
      logic [7:0] d;
      for (int i = 0; i < 6; i++) info[i] = 8'(8'h03 + i * 8'h21);
      build_frame(6, 1'b0);
      send_stream(1'b0);
      chk("R2 flag", int'(stat_flag), 1);
      chk("R5 eom", int'(stat_eom), 1);
      chk("R5 fcs ok", int'(stat_fcs_err), 0);
      chk("R4 len", int'(msg_len), 6);
      chk("R9 type", int'(msg_type), 8'h03);
      for (int i = 0; i < 6; i++) begin
         read_buf(i, d);
         chk("R4 R1 data", int'(d), int'(info[i]));
      end
      host_clear();
      chk("R9 cleared", int'({stat_eom, stat_flag, stat_abort, stat_fcs_err, stat_frm_err, stat_ovf}), 0);
   endtask

   task automatic t_stuffed_nr();
      logic [7:0] d;
      info[0] = 8'hFF; info[1] = 8'h7E; info[2] = 8'h3E; info[3] = 8'hFF; info[4] = 8'h1F;
      build_frame(5, 1'b0);
      send_stream(1'b1);
      chk("R3 eom", int'(stat_eom), 1);
      chk("R3 fcs ok", int'(stat_fcs_err), 0);
      chk("R1 nr len", int'(msg_len), 5);
      for (int i = 0; i < 5; i++) begin
         read_buf(i, d);
         chk("R3 data", int'(d), int'(info[i]));
      end
      host_clear();
   endtask

   task automatic t_bad_fcs();
      for (int i = 0; i < 4; i++) info[i] = 8'(8'h40 + i);
      build_frame(4, 1'b1);
      send_stream(1'b0);
      chk("R5 eom on bad", int'(stat_eom), 1);
      chk("R5 fcs err", int'(stat_fcs_err), 1);
      host_clear();
   endtask

   task automatic t_abort();
      put_flag();
      put_octet(8'h12); put_octet(8'h34); put_octet(8'h56);
      for (int i = 0; i < 8; i++) put_bit(1'b1);
      put_flag();
      send_stream(1'b0);
      chk("R6 abort", int'(stat_abort), 1);
      chk("R6 no eom", int'(stat_eom), 0);
      chk("R6 no frm err", int'(stat_frm_err), 0);
      chk("R6 len kept", int'(msg_len), 4);
      host_clear();
   endtask

   task automatic t_short();
      put_flag();
      put_octet(8'h01); put_octet(8'h02); put_octet(8'h03);
      put_flag();
      send_stream(1'b0);
      chk("R7 short err", int'(stat_frm_err), 1);
      chk("R7 short no eom", int'(stat_eom), 0);
      chk("R7 len kept", int'(msg_len), 4);
      host_clear();
   endtask

   task automatic t_misalign();
      put_flag();
      for (int i = 0; i < 5; i++) put_octet(8'(8'h10 + i));
      put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
      put_flag();
      send_stream(1'b1);
      chk("R7 align err", int'(stat_frm_err), 1);
      chk("R7 align no eom", int'(stat_eom), 0);
      host_clear();
   endtask

   task automatic t_long(input int n);
      logic [7:0] d;
      for (int i = 0; i < n; i++) info[i] = 8'(i * 7 + 1);
      build_frame(n, 1'b0);
      send_stream(1'b0);
      chk("R8 eom", int'(stat_eom), 1);
      chk("R8 fcs ok", int'(stat_fcs_err), 0);
      chk("R8 ovf", int'(stat_ovf), (n > 88) ? 1 : 0);
      chk("R8 len", int'(msg_len), (n > 88) ? 88 : n);
      read_buf(87, d);
      chk("R8 last slot", int'(d), int'(info[87]));
      read_buf(0, d);
      chk("R8 first slot", int'(d), int'(info[0]));
      host_clear();
   endtask

   logic done = 1'b0;

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run did not complete");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_good_gc();
      t_stuffed_nr();
      t_bad_fcs();
      t_abort();
      t_short();
      t_misalign();
      t_long(88);
      t_long(90);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule